// File: doc/BRIEF.md
# Phase-stepped I2C bus master

This block is an I2C bus master that a processor steers through a small byte-wide register file. Software never drives bus timing itself: it loads a byte, sets control bits and clears a completion flag. The controller then carries out exactly one bus phase and stops. A phase is a start, a repeated start, an address byte, a written data byte, a received data byte or a stop. Every phase except the stop ends with the completion flag raised and an outcome code in the status register. SCL stays held low until software clears the flag, so software may take any time to react.

The bus lines are open drain. The block only pulls SCL or SDA low through two output-enable pins, and it reads SDA back through a two-flop synchroniser. The SCL rate comes from a 7-bit divider setting. An optional interrupt output mirrors the flag. Slave operation, arbitration between masters, clock stretching and 10-bit addressing are not part of this block.

Top module: `i2c_phase_master`

## Requirements
- R1: Register byte offsets: data 0x04 (read/write), control 0x08 (read/write), status 0x0C on read, divider 0x0C on write (bits 6:3 = M, bits 2:0 = N), soft reset 0x1C on write. Control bits are: bit 7 interrupt enable, bit 6 enable, bit 5 START, bit 4 STOP, bit 3 flag, bit 2 ACK. Reads of any other offset, and of control bits 1:0, return 0.
- R2: After reset the control register reads 0x00, status reads 0xF8, irq is 0 and both line enables are 0.
- R3: With enable set, START from idle produces a start condition. The flag is then set with status 0x08, START reads back as 0, and SCL is held low.
- R4: The flag is cleared only by a control write with bit 3 at 0, and writing 1 never sets it. While the flag is set, SCL stays pulled low and the status code does not change, whatever START is set to.
- R5: The first byte sent after a start or repeated start is the address, MSB first. Its bit 0 selects read (1) or write (0). An acknowledged address reports 0x18 for write or 0x40 for read. An unacknowledged one reports 0x20 for write or 0x48 for read.
- R6: In write direction, clearing the flag sends the data register MSB first. An acknowledge reports 0x28 and no acknowledge reports 0x30.
- R7: In read direction, clearing the flag receives 8 bits MSB first into the data register. The master drives the ninth bit low when ACK is 1, which reports 0x50, and leaves it released when ACK is 0, which reports 0x58.
- R8: START set while the flag is held, followed by clearing the flag, gives a repeated start and reports 0x10.
- R9: STOP with the flag cleared produces a stop condition. Afterwards both lines are released, STOP reads back 0, the flag stays clear and status reads 0xF8. When STOP and START are both set, the stop comes first and a fresh start (0x08) follows.
- R10: One SCL period lasts 10*(M+1)*2^(N+1) clock cycles. SDA changes only while SCL is low, except for start and stop conditions.
- R11: Any write to offset 0x1C returns the controller to idle, clears the whole control register and releases SCL.
- R12: irq equals flag AND interrupt enable. START has no effect while enable is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 5 | Register byte offset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data for cpu_addr (combinational) |
| irq | output | 1 | Interrupt request |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
A behavioural slave on the open-drain lines acknowledges one 7-bit address and logs the bytes written to it. The bench goes after the following corner cases:
- A repeated start requested while the flag is still held. A design that acted on START without waiting for the flag would run the bus early or report 0x08 in place of 0x10.
- A final read byte sent with a NACK. If the ACK bit were ignored, the slave would keep driving SDA and the following stop would fail.
- Addresses that draw no acknowledge, in both directions. These catch swapped or merged no-acknowledge codes.
- STOP and START set together, plus a soft reset in the middle of a transfer.
- SCL period measured at two divider settings. This exposes an off-by-one in the divider formula.

// File: rtl/i2c_pm_pkg.sv
package i2c_pm_pkg;
  localparam int REG_AW = 5;

  localparam logic [REG_AW-1:0] OFS_DATA = 5'h04;
  localparam logic [REG_AW-1:0] OFS_CTRL = 5'h08;
  localparam logic [REG_AW-1:0] OFS_STAT = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_SRST = 5'h1C;

  localparam int CB_ACK   = 2;
  localparam int CB_FLAG  = 3;
  localparam int CB_STOP  = 4;
  localparam int CB_START = 5;
  localparam int CB_EN    = 6;
  localparam int CB_IEN   = 7;

  localparam logic [7:0] SC_START   = 8'h08;
  localparam logic [7:0] SC_RSTART  = 8'h10;
  localparam logic [7:0] SC_AW_ACK  = 8'h18;
  localparam logic [7:0] SC_AW_NACK = 8'h20;
  localparam logic [7:0] SC_DW_ACK  = 8'h28;
  localparam logic [7:0] SC_DW_NACK = 8'h30;
  localparam logic [7:0] SC_AR_ACK  = 8'h40;
  localparam logic [7:0] SC_AR_NACK = 8'h48;
  localparam logic [7:0] SC_DR_ACK  = 8'h50;
  localparam logic [7:0] SC_DR_NACK = 8'h58;
  localparam logic [7:0] SC_IDLE    = 8'hF8;

  typedef enum logic [3:0] {
    PH_IDLE, PH_START, PH_HOLD, PH_BIT_LO, PH_BIT_HI,
    PH_RS_LO, PH_RS_HI, PH_STOP_LO, PH_STOP_HI, PH_STOP_FREE
  } phase_e;
endpackage

// File: rtl/i2c_pm_baud.sv
module i2c_pm_baud #(
  parameter int M_W   = 4,
  parameter int N_W   = 3,
  parameter int DIV_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic [M_W-1:0] m_val,
  input  logic [N_W-1:0] n_val,
  output logic           tick
);
  logic [DIV_W-1:0] cnt_q, cnt_n, base, limit;

  always_comb begin
    base  = (DIV_W'(m_val) + DIV_W'(1)) * DIV_W'(5);
    limit = base << (32'(n_val) + 1);
    tick  = run && (cnt_q == limit - DIV_W'(1));
    cnt_n = (!run || tick) ? '0 : cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  // R10: a half period is at least 10 clocks, so ticks never come back to back
  a_r10_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/i2c_pm_engine.sv
module i2c_pm_engine
  import i2c_pm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sreset,
  input  logic       tick,
  input  logic       flag,
  input  logic       start_req,
  input  logic       stop_req,
  input  logic       ack_en,
  input  logic [7:0] tx_byte,
  input  logic       sda_in,
  output logic       run,
  output logic       done,
  output logic [7:0] done_code,
  output logic       rx_load,
  output logic [7:0] rx_byte,
  output logic       start_taken,
  output logic       stop_taken,
  output logic       scl_oe,
  output logic       sda_oe
);
  phase_e     ph_q, ph_n;
  logic [3:0] bit_q, bit_n;
  logic [7:0] sh_q, sh_n;
  logic       rw_q, rw_n, addr_q, addr_n, rep_q, rep_n, rx_q, rx_n;
  logic       sda_low_q, sda_low_n, scl_low_n;

  assign run     = (ph_q != PH_IDLE) && (ph_q != PH_HOLD);
  assign rx_byte = sh_q;

  always_comb begin
    ph_n = ph_q; bit_n = bit_q; sh_n = sh_q; rw_n = rw_q; addr_n = addr_q;
    rep_n = rep_q; rx_n = rx_q; sda_low_n = sda_low_q;
    done = 1'b0; done_code = SC_IDLE; rx_load = 1'b0;
    start_taken = 1'b0; stop_taken = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        sda_low_n = 1'b0;
        if (start_req) begin ph_n = PH_START; rep_n = 1'b0; sda_low_n = 1'b1; end
      end
      PH_START: if (tick) begin
        ph_n = PH_HOLD; done = 1'b1; start_taken = 1'b1; addr_n = 1'b1;
        done_code = rep_q ? SC_RSTART : SC_START;
      end
      PH_HOLD: if (!flag) begin
        if (stop_req) begin
          ph_n = PH_STOP_LO; sda_low_n = 1'b1;
        end else if (start_req) begin
          ph_n = PH_RS_LO; sda_low_n = 1'b0;
        end else begin
          ph_n = PH_BIT_LO; bit_n = '0;
          if (addr_q || !rw_q) begin
            sh_n = tx_byte; rx_n = 1'b0; sda_low_n = ~tx_byte[7];
            if (addr_q) rw_n = tx_byte[0];
          end else begin
            rx_n = 1'b1; sda_low_n = 1'b0;
          end
        end
      end
      PH_BIT_LO: if (tick) ph_n = PH_BIT_HI;
      PH_BIT_HI: if (tick) begin
        if (bit_q != 4'd8) begin
          sh_n  = {sh_q[6:0], sda_in};
          bit_n = bit_q + 4'd1;
          ph_n  = PH_BIT_LO;
          if (bit_q == 4'd7) sda_low_n = rx_q ? ack_en : 1'b0;
          else               sda_low_n = rx_q ? 1'b0 : ~sh_q[6];
        end else begin
          ph_n = PH_HOLD; done = 1'b1; addr_n = 1'b0;
          if (rx_q) begin
            rx_load = 1'b1;
            done_code = sda_low_q ? SC_DR_ACK : SC_DR_NACK;
          end else if (addr_q) begin
            if (rw_q) done_code = sda_in ? SC_AR_NACK : SC_AR_ACK;
            else      done_code = sda_in ? SC_AW_NACK : SC_AW_ACK;
          end else begin
            done_code = sda_in ? SC_DW_NACK : SC_DW_ACK;
          end
        end
      end
      PH_RS_LO: if (tick) ph_n = PH_RS_HI;
      PH_RS_HI: if (tick) begin ph_n = PH_START; rep_n = 1'b1; sda_low_n = 1'b1; end
      PH_STOP_LO: if (tick) ph_n = PH_STOP_HI;
      PH_STOP_HI: if (tick) begin ph_n = PH_STOP_FREE; sda_low_n = 1'b0; end
      PH_STOP_FREE: if (tick) begin ph_n = PH_IDLE; stop_taken = 1'b1; end
      default: ph_n = PH_IDLE;
    endcase
    if (sreset) begin ph_n = PH_IDLE; sda_low_n = 1'b0; end
    scl_low_n = (ph_n == PH_HOLD) || (ph_n == PH_BIT_LO) ||
                (ph_n == PH_RS_LO) || (ph_n == PH_STOP_LO);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE; bit_q <= '0; sh_q <= '0; rw_q <= 1'b0; addr_q <= 1'b0;
      rep_q <= 1'b0; rx_q <= 1'b0; sda_low_q <= 1'b0; scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else begin
      ph_q <= ph_n; bit_q <= bit_n; sh_q <= sh_n; rw_q <= rw_n; addr_q <= addr_n;
      rep_q <= rep_n; rx_q <= rx_n; sda_low_q <= sda_low_n;
      scl_oe <= scl_low_n;
      sda_oe <= sda_low_q;   // SDA trails SCL by one clock of hold time
    end
  end

  // R10: data line is steady for the whole SCL-high half of a data bit
  a_r10_sda_steady: assert property (@(posedge clk) disable iff (!rst_n || sreset)
    (ph_q == PH_BIT_HI && $past(ph_q) == PH_BIT_HI) |-> $stable(sda_oe));
  // R10: SCL is released throughout the high half of a bit
  a_r10_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_BIT_HI) |-> !scl_oe);
endmodule

// File: rtl/i2c_phase_master.sv
module i2c_phase_master
  import i2c_pm_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic              irq,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe
);
  localparam int M_W = 4;
  localparam int N_W = 3;
  localparam int BAUD_W = M_W + N_W;
  localparam logic [BAUD_W-1:0] BAUD_RST = 7'h24;

  logic ack_q, stop_q, start_q, en_q, ien_q, flag_q;
  logic ack_n, stop_n, start_n, en_n, ien_n, flag_n;
  logic [7:0] data_q, data_n, code_q, code_n;
  logic [BAUD_W-1:0] baud_q, baud_n;
  logic [1:0] sda_sync_q;
  logic wr_ctrl, wr_data, wr_baud, wr_srst;
  logic tick, run, done, rx_load, start_taken, stop_taken;
  logic [7:0] done_code, rx_byte, ctrl_rd, stat_rd;
  wire unused_wbits = ^cpu_wdata[1:0];

  assign wr_ctrl = cpu_wr && (cpu_addr == OFS_CTRL);
  assign wr_data = cpu_wr && (cpu_addr == OFS_DATA);
  assign wr_baud = cpu_wr && (cpu_addr == OFS_STAT);
  assign wr_srst = cpu_wr && (cpu_addr == OFS_SRST);

  i2c_pm_baud #(.M_W(M_W), .N_W(N_W), .DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(run),
    .m_val(baud_q[BAUD_W-1:N_W]), .n_val(baud_q[N_W-1:0]), .tick(tick));

  i2c_pm_engine u_eng (
    .clk(clk), .rst_n(rst_n), .sreset(wr_srst), .tick(tick), .flag(flag_q),
    .start_req(start_q && en_q), .stop_req(stop_q), .ack_en(ack_q),
    .tx_byte(data_q), .sda_in(sda_sync_q[1]), .run(run), .done(done),
    .done_code(done_code), .rx_load(rx_load), .rx_byte(rx_byte),
    .start_taken(start_taken), .stop_taken(stop_taken),
    .scl_oe(scl_oe), .sda_oe(sda_oe));

  always_comb begin
    ack_n   = wr_ctrl ? cpu_wdata[CB_ACK] : ack_q;
    en_n    = wr_ctrl ? cpu_wdata[CB_EN]  : en_q;
    ien_n   = wr_ctrl ? cpu_wdata[CB_IEN] : ien_q;
    start_n = wr_ctrl ? cpu_wdata[CB_START] : (start_q && !start_taken);
    stop_n  = wr_ctrl ? cpu_wdata[CB_STOP]  : (stop_q && !stop_taken);
    flag_n  = done || (flag_q && !(wr_ctrl && !cpu_wdata[CB_FLAG]));
    code_n  = done ? done_code : code_q;
    data_n  = rx_load ? rx_byte : (wr_data ? cpu_wdata : data_q);
    baud_n  = wr_baud ? cpu_wdata[BAUD_W-1:0] : baud_q;
    if (wr_srst) begin
      {ack_n, en_n, ien_n, start_n, stop_n, flag_n} = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ack_q, en_q, ien_q, start_q, stop_q, flag_q} <= '0;
      code_q <= SC_IDLE; data_q <= '0; baud_q <= BAUD_RST; sda_sync_q <= 2'b11;
    end else begin
      ack_q <= ack_n; en_q <= en_n; ien_q <= ien_n;
      start_q <= start_n; stop_q <= stop_n; flag_q <= flag_n;
      code_q <= code_n; data_q <= data_n; baud_q <= baud_n;
      sda_sync_q <= {sda_sync_q[0], sda_in};
    end
  end

  assign ctrl_rd = {ien_q, en_q, start_q, stop_q, flag_q, ack_q, 2'b00};
  assign stat_rd = flag_q ? code_q : SC_IDLE;
  assign irq     = flag_q && ien_q;

  always_comb begin
    unique case (cpu_addr)
      OFS_DATA: cpu_rdata = data_q;
      OFS_CTRL: cpu_rdata = ctrl_rd;
      OFS_STAT: cpu_rdata = stat_rd;
      default:  cpu_rdata = 8'h00;
    endcase
  end

  // R4: a held flag keeps SCL pulled low
  a_r4_flag_freezes_scl: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && $past(flag_q)) |-> scl_oe);
  // R4: the reported code cannot move while the flag stays set
  a_r4_code_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && $past(flag_q)) |-> $stable(stat_rd));
  // R9: the flag only rises when the engine finishes a phase (never for a stop)
  a_r9_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(done));
  // R11: soft reset idles the block on the next cycle
  a_r11_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    wr_srst |=> (ctrl_rd == 8'h00) && !scl_oe);
endmodule

// File: tb/i2c_phase_master_test.sv
module i2c_phase_master_test;
  localparam logic [4:0] A_DATA = 5'h04, A_CTRL = 5'h08, A_STAT = 5'h0C, A_SRST = 5'h1C;
  localparam logic [6:0] SLV = 7'h52;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] cpu_addr = '0;
  logic cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = '0, cpu_rdata;
  logic irq, scl_oe, sda_oe, sda_in;
  logic sl_low = 1'b0;
  wire scl_w = ~scl_oe;
  wire sda_w = ~(sda_oe | sl_low);
  assign sda_in = sda_w;

  always #5 clk = ~clk;

  i2c_phase_master uut (.clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq), .sda_in(sda_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe));

  int nvec = 0, nerr = 0, cyc = 0, rise_last = 0, rise_prev = 0;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge scl_w) begin rise_prev = rise_last; rise_last = cyc; end

  // behavioural slave
  int sl_bit = 0, sl_nlog = 0, sl_stops = 0, sl_ridx = 0;
  logic [7:0] sl_sh = '0, sl_tx = '0;
  logic sl_isaddr = 1'b0, sl_hit = 1'b0, sl_rd = 1'b0, sl_send = 1'b0, sl_mack = 1'b0;
  logic sl_nack_data = 1'b0;
  logic [7:0] sl_log [0:15];
  logic [7:0] rdmem [0:3];

  always @(negedge sda_w) if (scl_w === 1'b1) begin
    sl_bit = 0; sl_isaddr = 1'b1; sl_hit = 1'b0; sl_send = 1'b0; sl_low = 1'b0;
  end
  always @(posedge sda_w) if (scl_w === 1'b1) begin
    sl_stops++; sl_hit = 1'b0; sl_send = 1'b0; sl_low = 1'b0; sl_bit = 0;
  end
  always @(posedge scl_w) begin
    if (sl_bit < 8) sl_sh = {sl_sh[6:0], sda_w};
    else if (sl_bit == 8) sl_mack = !sda_w;
    sl_bit++;
  end
  always @(negedge scl_w) begin
    if (sl_bit == 8) begin
      if (sl_isaddr) begin
        sl_hit = (sl_sh[7:1] == SLV); sl_rd = sl_sh[0]; sl_low = sl_hit;
      end else if (sl_hit && !sl_rd) begin
        sl_log[sl_nlog % 16] = sl_sh; sl_nlog++; sl_low = !sl_nack_data;
      end else sl_low = 1'b0;
    end else if (sl_bit == 9) begin
      sl_bit = 0;
      sl_send = sl_hit && sl_rd && (sl_isaddr || sl_mack);
      sl_isaddr = 1'b0;
      if (sl_send) begin
        sl_tx = rdmem[sl_ridx % 4]; sl_ridx++; sl_low = !sl_tx[7];
      end else sl_low = 1'b0;
    end else if (sl_bit >= 1 && sl_bit <= 7 && sl_send) sl_low = !sl_tx[7 - sl_bit];
    else sl_low = 1'b0;
  end

  function automatic logic [7:0] exp_addr(input logic rd, input logic ack);
    if (rd) return ack ? 8'h40 : 8'h48;
    return ack ? 8'h18 : 8'h20;
  endfunction
  function automatic logic [7:0] exp_wr(input logic ack);
    return ack ? 8'h28 : 8'h30;
  endfunction
  function automatic logic [7:0] exp_rd(input logic ack);
    return ack ? 8'h50 : 8'h58;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask
  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk); cpu_wr = 1'b0;
  endtask
  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); cpu_addr = a; #1 d = cpu_rdata;
  endtask
  task automatic wait_flag(input string tag);
    logic [7:0] c;
    for (int i = 0; i < 20000; i++) begin
      rd(A_CTRL, c);
      if (c[3]) return;
    end
    chk({tag, " flag timeout"}, 0, 1);
  endtask
  task automatic step(input logic [7:0] ctl, input logic [7:0] code, input string tag);
    logic [7:0] s;
    wr(A_CTRL, ctl); wait_flag(tag); rd(A_STAT, s); chk(tag, s, code);
  endtask
  task automatic do_stop(input string tag);
    logic [7:0] c;
    wr(A_CTRL, 8'h50); repeat (200) @(negedge clk);
    rd(A_CTRL, c); chk({tag, " ctrl after stop"}, c, 8'h40);
  endtask

  initial begin
    logic [7:0] v, b;
    logic hit, nack;
    logic [6:0] adr;
    int nb, stops0, idx0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) rdmem[i] = 8'($urandom);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state
    rd(A_CTRL, v); chk("R2 ctrl", v, 8'h00);
    rd(A_STAT, v); chk("R2 status", v, 8'hF8);
    chk("R2 lines", {irq, scl_oe, sda_oe}, 3'b000);
    rd(5'h14, v); chk("R1 unmapped read", v, 8'h00);
    // R4 writing 1 to flag never sets it
    wr(A_CTRL, 8'h48); rd(A_CTRL, v); chk("R4 flag write one", v, 8'h40);
    // R12 START without enable
    wr(A_CTRL, 8'h20); repeat (150) @(negedge clk);
    rd(A_STAT, v); chk("R12 start ignored status", v, 8'hF8);
    chk("R12 start ignored scl", scl_oe, 0);
    wr(A_CTRL, 8'h00);
    wr(A_STAT, 8'h00);                       // fastest divider: M=0, N=0
    // directed write transaction
    step(8'h60, 8'h08, "R3 start");
    rd(A_CTRL, v); chk("R3 start self-clears", v[5], 0);
    repeat (100) @(negedge clk);
    chk("R4 scl held", scl_oe, 1);
    rd(A_STAT, v); chk("R4 code frozen", v, 8'h08);
    chk("R12 irq off when disabled", irq, 0);
    wr(A_DATA, {SLV, 1'b0}); step(8'h40, 8'h18, "R5 write addr ack");
    sl_nack_data = 1'b0; b = 8'hA5;
    wr(A_DATA, b); step(8'h40, 8'h28, "R6 data ack");
    chk("R6 slave got byte", sl_log[(sl_nlog - 1) % 16], b);
    chk("R10 period M0N0", rise_last - rise_prev, 20);
    sl_nack_data = 1'b1; b = 8'h3C;
    wr(A_DATA, b); step(8'h40, 8'h30, "R6 data nack");
    chk("R6 slave got byte 2", sl_log[(sl_nlog - 1) % 16], b);
    wr(A_CTRL, 8'hC8); chk("R12 irq", irq, 1);
    // R8 repeated start requested while flag still held
    wr(A_CTRL, 8'h68); repeat (100) @(negedge clk);
    rd(A_STAT, v); chk("R4 frozen with START", v, 8'h30);
    chk("R4 scl held with START", scl_oe, 1);
    step(8'h60, 8'h10, "R8 repeated start");
    idx0 = sl_ridx;
    wr(A_DATA, {SLV, 1'b1}); step(8'h44, 8'h40, "R5 read addr ack");
    step(8'h44, 8'h50, "R7 read ack");
    rd(A_DATA, v); chk("R7 byte0", v, rdmem[idx0 % 4]);
    step(8'h40, 8'h58, "R7 read nack");
    rd(A_DATA, v); chk("R7 byte1", v, rdmem[(idx0 + 1) % 4]);
    stops0 = sl_stops;
    do_stop("R9");
    rd(A_STAT, v); chk("R9 status idle", v, 8'hF8);
    chk("R9 lines released", {scl_oe, sda_oe}, 2'b00);
    chk("R9 slave saw stop", sl_stops, stops0 + 1);
    // R5 no acknowledge on read address
    step(8'h60, 8'h08, "R3 start 2");
    wr(A_DATA, {SLV ^ 7'h11, 1'b1}); step(8'h40, 8'h48, "R5 read addr nack");
    // R9 STOP and START together
    stops0 = sl_stops;
    step(8'h70, 8'h08, "R9 stop then start");
    chk("R9 stop before start", sl_stops, stops0 + 1);
    rd(A_CTRL, v); chk("R9 bits cleared", v[5:4], 2'b00);
    do_stop("R9 b");
    // R10 slower divider M=1 N=1
    wr(A_STAT, 8'h09);
    step(8'h60, 8'h08, "R3 start 3");
    wr(A_DATA, {SLV, 1'b0}); step(8'h40, 8'h18, "R5 addr slow");
    sl_nack_data = 1'b0;
    wr(A_DATA, 8'h96); step(8'h40, 8'h28, "R6 data slow");
    chk("R10 period M1N1", rise_last - rise_prev, 80);
    do_stop("R9 c");
    wr(A_STAT, 8'h00);
    // random write transactions
    for (int it = 0; it < 8; it++) begin
      hit = ($urandom % 4) != 0;
      adr = hit ? SLV : (SLV ^ 7'(1 + $urandom % 127));
      step(8'h60, 8'h08, "R3 rnd start");
      wr(A_DATA, {adr, 1'b0}); step(8'h40, exp_addr(1'b0, hit), "R5 rnd addr");
      if (hit) begin
        nb = 1 + $urandom % 3;
        for (int k = 0; k < nb; k++) begin
          b = 8'($urandom); nack = $urandom % 2; sl_nack_data = nack;
          wr(A_DATA, b); step(8'h40, exp_wr(!nack), "R6 rnd data");
          chk("R6 rnd slave byte", sl_log[(sl_nlog - 1) % 16], b);
        end
      end
      do_stop("R9 rnd");
    end
    // random read transaction with ACK pattern
    step(8'h60, 8'h08, "R3 rd start");
    idx0 = sl_ridx;
    wr(A_DATA, {SLV, 1'b1}); step(8'h44, exp_addr(1'b1, 1'b1), "R5 rd addr");
    for (int k = 0; k < 3; k++) begin
      step((k == 2) ? 8'h40 : 8'h44, exp_rd(k != 2), "R7 rnd read");
      rd(A_DATA, v); chk("R7 rnd byte", v, rdmem[(idx0 + k) % 4]);
    end
    do_stop("R9 rd");
    // R11 soft reset in the middle of a transfer
    step(8'h60, 8'h08, "R3 start srst");
    wr(A_SRST, 8'h00);
    rd(A_CTRL, v); chk("R11 ctrl cleared", v, 8'h00);
    rd(A_STAT, v); chk("R11 status", v, 8'hF8);
    chk("R11 scl released", scl_oe, 0);
    step(8'h60, 8'h08, "R11 start after reset");
    do_stop("R11");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    nvec++; nerr++;
    $display("FAIL watchdog: actual %0d expected below 190000 cycles", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule